// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This controller-side block owns the DDR SDRAM command bus from power-up until the memory is ready for normal traffic. After reset it holds clock enable low and drives NOP for a stabilization interval. That interval is a number of microseconds multiplied by the clock frequency in MHz. It then raises clock enable, drives a few more NOP cycles to give the device setup and hold margin, and issues the fixed start-up command series. Each command is followed by its minimum spacing.

The series is fixed: a precharge of all banks, a write of the extended mode register, and a mode register write with the DLL-reset bit (A8) set. A second precharge of all banks follows, then a parameter-controlled number of auto-refreshes (at least two), and last a mode register write with A8 cleared. When the final mode register write has settled, `ready` goes high and stays high. Read permission comes from a separate flag, `rd_ok`. It rises only once a DLL-lock cycle count has elapsed since the DLL-reset write, so the rest of the sequence can finish before the DLL locks. All mode values, spacings and counts are parameters.

Top module: `ddr_init_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the following cycle shows `cke`=0, NOP on the command pins, and `ready`=0 and `rd_ok`=0. This holds even when reset arrives in the middle of the sequence.
- R2: After reset is released, `cke` stays low and only NOP is driven for `CLK_MHZ*STABLE_US` cycles. `cke` rises in exactly that cycle and then stays high.
- R3: The first non-NOP command comes `CKE_NOPS` cycles after `cke` rises, and all cycles in between are NOP.
- R4: The commands appear in this order: precharge-all, extended mode write, mode write with DLL reset, precharge-all, `N_REF` auto-refreshes, final mode write. No other command is issued.
- R5: The command pins {cs_n,ras_n,cas_n,we_n} are 0111 for NOP, 0010 for precharge, 0001 for auto-refresh and 0000 for a mode register write.
- R6: A precharge drives `addr[10]`=1, all other address bits 0 and `ba`=0.
- R7: The extended mode write uses `ba`=1 and `addr`=`EMR_VAL`. The first mode write uses `ba`=0 and `addr`=`MR_VAL` with bit 8 set. The final mode write uses `ba`=0 and `addr`=`MR_VAL` with bit 8 cleared.
- R8: The next command follows a precharge exactly `T_RP` cycles later, a mode or extended mode write exactly `T_MRD` cycles later, and an auto-refresh exactly `T_RFC` cycles later.
- R9: Exactly `N_REF` auto-refresh commands are issued.
- R10: `ready` rises exactly `T_MRD` cycles after the final mode write and then stays high. While `ready` is high, only NOP is driven.
- R11: `rd_ok` rises in the later of two cycles: `DLL_LOCK` cycles after the DLL-reset mode write, or the cycle `ready` rises. Once high it stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| ready | output | 1 | Initialization complete (level) |
| rd_ok | output | 1 | READ commands permitted (level) |

## Verification
The bench builds the block with a 1 MHz clock figure and a 20 µs wait, which gives a 20-cycle stabilization interval. It also uses small distinct spacings (precharge 3, mode write 2, refresh 7, clock-enable margin 3). With these values every gap in the series is short but can still be told apart from the others. Three refreshes are configured so that the loop is exercised past its minimum. A mode value with bit 8 set shows that the final write clears it. The DLL-lock count is 40, larger than the rest of the series, so `rd_ok` visibly trails `ready`. A reset in the middle of the sequence is also applied.

// File: rtl/ddr_init_seq.sv
module ddr_init_seq #(
  parameter int CLK_MHZ   = 50,
  parameter int STABLE_US = 200,
  parameter int CKE_NOPS  = 2,
  parameter int T_RP      = 3,
  parameter int T_MRD     = 2,
  parameter int T_RFC     = 8,
  parameter int N_REF     = 2,
  parameter int DLL_LOCK  = 200,
  parameter int ADDR_W    = 13,
  parameter int BA_W      = 2,
  parameter logic [ADDR_W-1:0] EMR_VAL = '0,
  parameter logic [ADDR_W-1:0] MR_VAL  = ADDR_W'(32'h0032)
) (
  input  logic              clk,
  input  logic              rst,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              ready,
  output logic              rd_ok
);
  localparam int STABLE_CYC = CLK_MHZ * STABLE_US;
  localparam int G1   = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int G2   = (G1 > T_RFC) ? G1 : T_RFC;
  localparam int G3   = (G2 > CKE_NOPS) ? G2 : CKE_NOPS;
  localparam int MAXC = (G3 > STABLE_CYC) ? G3 : STABLE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam int DLL_W = $clog2(DLL_LOCK + 1);
  localparam int REF_W = $clog2(N_REF + 1);

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;
  localparam logic [ADDR_W-1:0] A10 = ADDR_W'(1) << 10;
  localparam logic [ADDR_W-1:0] A8  = ADDR_W'(1) << 8;

  typedef enum logic [3:0] {
    S_WAIT, S_PRE1, S_EMRS, S_MRSD, S_PRE2, S_REF, S_MRS, S_DONE, S_IDLE
  } step_t;

  step_t              step;
  logic [CNT_W-1:0]   cnt;
  logic [DLL_W-1:0]   dll_cnt;
  logic               dll_seen;
  logic [REF_W-1:0]   ref_left;
  logic [3:0]         cmd_q;
  logic               cke_q, ready_q;
  logic [BA_W-1:0]    ba_q;
  logic [ADDR_W-1:0]  addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      step     <= S_WAIT;
      cnt      <= CNT_W'(STABLE_CYC - 1);
      dll_cnt  <= '0;
      dll_seen <= 1'b0;
      ref_left <= REF_W'(N_REF);
      cmd_q    <= C_NOP;
      cke_q    <= 1'b0;
      ready_q  <= 1'b0;
      ba_q     <= '0;
      addr_q   <= '0;
    end else begin
      cmd_q  <= C_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      if (dll_cnt != '0) dll_cnt <= dll_cnt - 1'b1;
      if (cnt != '0) cnt <= cnt - 1'b1;
      else begin
        case (step)
          S_WAIT: begin
            cke_q <= 1'b1;
            cnt   <= CNT_W'(CKE_NOPS - 1);
            step  <= S_PRE1;
          end
          S_PRE1: begin
            cmd_q  <= C_PRE;
            addr_q <= A10;
            cnt    <= CNT_W'(T_RP - 1);
            step   <= S_EMRS;
          end
          S_EMRS: begin
            cmd_q  <= C_MRS;
            ba_q   <= BA_W'(1);
            addr_q <= EMR_VAL;
            cnt    <= CNT_W'(T_MRD - 1);
            step   <= S_MRSD;
          end
          S_MRSD: begin
            cmd_q    <= C_MRS;
            addr_q   <= MR_VAL | A8;
            cnt      <= CNT_W'(T_MRD - 1);
            dll_cnt  <= DLL_W'(DLL_LOCK);
            dll_seen <= 1'b1;
            step     <= S_PRE2;
          end
          S_PRE2: begin
            cmd_q    <= C_PRE;
            addr_q   <= A10;
            cnt      <= CNT_W'(T_RP - 1);
            ref_left <= REF_W'(N_REF);
            step     <= S_REF;
          end
          S_REF: begin
            cmd_q <= C_REF;
            cnt   <= CNT_W'(T_RFC - 1);
            if (ref_left == REF_W'(1)) step <= S_MRS;
            else ref_left <= ref_left - 1'b1;
          end
          S_MRS: begin
            cmd_q  <= C_MRS;
            addr_q <= MR_VAL & ~A8;
            cnt    <= CNT_W'(T_MRD - 1);
            step   <= S_DONE;
          end
          S_DONE: begin
            ready_q <= 1'b1;
            step    <= S_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  assign cke   = cke_q;
  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign ba    = ba_q;
  assign addr  = addr_q;
  assign ready = ready_q;
  assign rd_ok = ready_q & dll_seen & (dll_cnt == '0);
endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic              ready,
  input logic              rd_ok
);
  logic [3:0] cmd;
  assign cmd = {cs_n, ras_n, cas_n, we_n};

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!cke && !ready && !rd_ok && cmd == 4'b0111));

  p_cke_low_nop_r2: assert property (@(posedge clk) disable iff (rst)
    !cke |-> cmd == 4'b0111);

  p_cke_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);

  p_pre_all_banks_r6: assert property (@(posedge clk) disable iff (rst)
    cmd == 4'b0010 |-> addr[10]);

  p_ready_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

  p_idle_after_ready_r10: assert property (@(posedge clk) disable iff (rst)
    ready |-> cmd == 4'b0111);

  p_rdok_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    rd_ok |=> rd_ok);
endmodule

bind ddr_init_seq ddr_init_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .addr(addr), .ready(ready), .rd_ok(rd_ok)
);

// File: tb/ddr_init_seq_tb.sv
module ddr_init_seq_tb;
  localparam int CLK_MHZ = 1, STABLE_US = 20, CKE_NOPS = 3;
  localparam int T_RP = 3, T_MRD = 2, T_RFC = 7, N_REF = 3, DLL_LOCK = 40;
  localparam logic [12:0] EMR_VAL = 13'h0002, MR_VAL = 13'h0122;
  localparam int STABLE = CLK_MHZ * STABLE_US;

  logic clk = 1'b0, rst = 1'b1;
  logic cke, cs_n, ras_n, cas_n, we_n, ready, rd_ok;
  logic [1:0] ba;
  logic [12:0] addr;

  always #10 clk = ~clk;

  ddr_init_seq #(
    .CLK_MHZ(CLK_MHZ), .STABLE_US(STABLE_US), .CKE_NOPS(CKE_NOPS),
    .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC), .N_REF(N_REF),
    .DLL_LOCK(DLL_LOCK), .EMR_VAL(EMR_VAL), .MR_VAL(MR_VAL)
  ) u_dut (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .ready(ready), .rd_ok(rd_ok)
  );

  typedef struct {
    logic [3:0]  cmd;
    logic [1:0]  ba;
    logic [12:0] addr;
    int          gap;
    bit          dll;
    string       tag;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] c, input logic [1:0] b, input logic [12:0] a,
                      input int gap, input bit dll, input string tag);
    exp_t e;
    e.cmd = c; e.ba = b; e.addr = a; e.gap = gap; e.dll = dll; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic load_expected();
    q.delete();
    push(4'b0010, 2'd0, 13'h0400, CKE_NOPS, 1'b0, "R3 R6 precharge1");
    push(4'b0000, 2'd1, EMR_VAL, T_RP, 1'b0, "R7 emrs");
    push(4'b0000, 2'd0, MR_VAL | 13'h0100, T_MRD, 1'b1, "R7 mrs_dll");
    push(4'b0010, 2'd0, 13'h0400, T_MRD, 1'b0, "R6 precharge2");
    for (int i = 0; i < N_REF; i++)
      push(4'b0001, 2'd0, 13'h0000, (i == 0) ? T_RP : T_RFC, 1'b0, "R9 refresh");
    push(4'b0000, 2'd0, MR_VAL & ~13'h0100, T_RFC, 1'b0, "R7 mrs_final");
  endtask

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  bit cke_prev, ready_prev, rdok_prev;
  int last_evt, dll_at, ready_at, refs;

  always @(negedge clk) begin
    if (rst) begin
      cke_prev = 0; ready_prev = 0; rdok_prev = 0;
      last_evt = 0; dll_at = -1; ready_at = -1; refs = 0;
    end else begin
      logic [3:0] cmd;
      cmd = {cs_n, ras_n, cas_n, we_n};
      if (!cke) check(cmd == 4'b0111, "R2 nop while cke low", cmd, 4'b0111);
      if (cke && !cke_prev) begin
        check(cyc == STABLE, "R2 cke rise cycle", cyc, STABLE);
        last_evt = cyc;
      end
      if (cke_prev && !cke) check(0, "R2 cke fell", 0, 1);
      if (cmd != 4'b0111) begin
        if (cmd == 4'b0001) refs++;
        if (q.size() == 0) check(0, "R4 unexpected command", cmd, 4'b0111);
        else begin
          exp_t e;
          e = q.pop_front();
          check(cmd == e.cmd, {"R4 R5 cmd ", e.tag}, cmd, e.cmd);
          check(ba == e.ba && addr == e.addr, {"R6 R7 ba/addr ", e.tag},
                {ba, addr}, {e.ba, e.addr});
          check(cyc - last_evt == e.gap, {"R8 gap ", e.tag}, cyc - last_evt, e.gap);
          if (e.dll) dll_at = cyc;
        end
        last_evt = cyc;
      end
      if (ready && !ready_prev) begin
        ready_at = cyc;
        check(cyc - last_evt == T_MRD, "R10 ready timing", cyc - last_evt, T_MRD);
        check(q.size() == 0, "R4 sequence complete at ready", q.size(), 0);
      end
      if (ready_prev && !ready) check(0, "R10 ready fell", 0, 1);
      if (ready && ready_prev && cmd != 4'b0111)
        check(0, "R10 command after ready", cmd, 4'b0111);
      if (rd_ok && !rdok_prev) begin
        int want;
        want = (dll_at + DLL_LOCK > ready_at) ? dll_at + DLL_LOCK : ready_at;
        check(dll_at >= 0 && cyc == want, "R11 rd_ok timing", cyc, want);
      end
      cke_prev = cke; ready_prev = ready; rdok_prev = rd_ok;
    end
  end

  task automatic run_to_rdok(input string what);
    int i;
    for (i = 0; i < 3000 && !rd_ok; i++) @(negedge clk);
    if (!rd_ok) check(0, {"R11 watchdog ", what}, 0, 1);
  endtask

  initial begin
    load_expected();
    repeat (3) @(negedge clk);
    check(!cke && !ready && !rd_ok && {cs_n, ras_n, cas_n, we_n} == 4'b0111,
          "R1 reset state", {cke, ready, rd_ok, cs_n, ras_n, cas_n, we_n}, 7'b0000111);
    rst = 1'b0;
    run_to_rdok("pass1");
    repeat (10) @(negedge clk);
    check(refs == N_REF, "R9 refresh count", refs, N_REF);
    check(ready && rd_ok, "R11 levels hold", {ready, rd_ok}, 2'b11);

    rst = 1'b1;
    @(negedge clk);
    load_expected();
    rst = 1'b0;
    while (cyc < STABLE + CKE_NOPS + T_RP + 1) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(!cke && !ready && {cs_n, ras_n, cas_n, we_n} == 4'b0111,
          "R1 mid-sequence reset", {cke, ready, cs_n, ras_n, cas_n, we_n}, 6'b000111);
    load_expected();
    rst = 1'b0;
    run_to_rdok("pass2");
    repeat (5) @(negedge clk);
    check(refs == N_REF, "R9 refresh count after reset", refs, N_REF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL R11 global watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule